// File: doc/BRIEF.md
# Fractional-Prescaled Core Timer

This block is a free-running counter that serves as the time base for a processor's generic timers. It counts ticks from one of two strobe sources. Both sources arrive as single-cycle enables in the block's own clock domain: a crystal reference strobe and an alternate strobe. The count rate is set by a 32-bit fractional prescaler, so the counter advances at the selected tick rate times the prescaler value divided by 2^31.

Inside, a phase accumulator keeps a 31-bit fraction. Each selected tick adds the prescaler value to that fraction. Every whole multiple of 2^31 that results moves the count forward by one step, and a step is one or two counts depending on a control bit. Software reaches the block through a small word-addressed register port. Through it, software sets the source and the step, programs the prescaler, and reads the count as two halves. Reading the low half captures the high half, so a low-then-high read gives one consistent value even if the count crosses a half boundary in between.

Top module: `frac_core_timer`

## Requirements
- R1: After reset the control value, the prescaler and the count are all zero, and `rdata_o` is zero in every cycle in which `rd_en_i` is low.
- R2: Registers are selected by `addr_i`. Address 0 is control: bit 8 is the source select and bit 9 is the step select, and all other bits read as zero. Address 1 is the prescaler and reads back as written. Address 2 returns the low CNT_LO_W bits of the count. Address 3 returns the captured high part. Both count reads are zero-extended.
- R3: Control bit 8 chooses the strobe. A value of 0 selects `ref_tick_i` and a value of 1 selects `alt_tick_i`. A strobe on the source that is not selected leaves the count unchanged.
- R4: On each selected tick with no prescaler write, the sum S = fraction + prescaler is formed. The count advances by floor(S / 2^31) steps, the fraction becomes S mod 2^31, and the count wraps modulo 2^CNT_W.
- R5: With a prescaler of 0x80000000, the count advances by exactly one step per selected tick.
- R6: With a prescaler of 0, which is the reset value, the count never changes.
- R7: Control bit 9 set to 0 makes a step worth 1 count. Set to 1, a step is worth 2 counts.
- R8: Writing the prescaler clears the fraction. A selected tick in the same cycle as that write is discarded.
- R9: A read of address 2 captures the high part of the count in that cycle. Reads of address 3 return that captured value until the next read of address 2.
- R10: Writes to addresses 2 and 3 are ignored and leave the count unchanged.
- R11: The count is updated at the clock edge that samples a tick. Read data is combinational, so a read in the tick cycle returns the old count and a read in the next cycle returns the new count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | Crystal reference tick strobe |
| alt_tick_i | input | 1 | Alternate source tick strobe |
| wr_en_i | input | 1 | Register write enable |
| rd_en_i | input | 1 | Register read enable |
| addr_i | input | 2 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |

## Verification
The count and the captured high part change at the clock edge that samples the tick or the low read. The fraction clear from a prescaler write also takes effect at that edge. Read data is combinational, with no register delay. The bench drives each stimulus at the falling edge and updates its arithmetic model just after the rising edge. It samples `rdata_o` one nanosecond after it drives a read, so every read reflects all edges before that cycle and none after it. One directed case reads in the tick cycle itself and then again in the cycle after, which pins the zero-cycle read path and the one-edge count update.

// File: rtl/frac_tmr_pkg.sv
package frac_tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PRESC  = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_CNT_HI = 2'd3
  } reg_sel_e;

  localparam int CTRL_SRC_BIT  = 8;
  localparam int CTRL_STEP_BIT = 9;

  typedef struct packed {
    logic step2;
    logic alt_src;
  } ctrl_t;
endpackage

// File: rtl/tmr_cfg_regs.sv
module tmr_cfg_regs
  import frac_tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] presc_o,
  output logic              presc_wr_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] presc_q;
  logic              ctrl_wr;

  assign ctrl_wr    = wr_en_i && (addr_i == REG_CTRL);
  assign presc_wr_o = wr_en_i && (addr_i == REG_PRESC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      presc_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.alt_src <= wdata_i[CTRL_SRC_BIT];
        ctrl_q.step2   <= wdata_i[CTRL_STEP_BIT];
      end
      if (presc_wr_o) presc_q <= wdata_i;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign presc_o = presc_q;
endmodule

// File: rtl/tmr_phase_acc.sv
module tmr_phase_acc #(
  parameter int PRESC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic [1:0]         units_o
);
  localparam int FRAC_W = PRESC_W - 1;

  logic [FRAC_W-1:0] frac_q;
  logic [PRESC_W:0]  sum;

  assign sum = {2'b00, frac_q} + {1'b0, presc_i};

  // whole steps crossed; a prescaler write drops the tick
  assign units_o = (tick_i && !clr_i) ? sum[PRESC_W:PRESC_W-1] : 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frac_q <= '0;
    else if (clr_i)  frac_q <= '0;
    else if (tick_i) frac_q <= sum[FRAC_W-1:0];
  end

  AST_FRAC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (frac_q == '0)); // R8
  AST_FRAC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(frac_q)); // R4
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       units_i,
  input  logic             step2_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       delta;

  assign delta = step2_i ? {units_i, 1'b0} : {1'b0, units_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + {{(CNT_W-3){1'b0}}, delta};
  end

  assign cnt_o = cnt_q;

  AST_STEP2_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step2_i |=> (cnt_q[0] == $past(cnt_q[0]))); // R7
endmodule

// File: rtl/tmr_read_port.sv
module tmr_read_port
  import frac_tmr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] presc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = CNT_W - LO_W;

  logic [HI_W-1:0]   hi_q;
  logic              lo_rd;
  logic [DATA_W-1:0] ctrl_word;

  assign lo_rd = rd_en_i && (addr_i == REG_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (lo_rd) hi_q <= cnt_i[CNT_W-1:LO_W];
  end

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_SRC_BIT]  = ctrl_i.alt_src;
    ctrl_word[CTRL_STEP_BIT] = ctrl_i.step2;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_CTRL:   rdata_o = ctrl_word;
        REG_PRESC:  rdata_o = presc_i;
        REG_CNT_LO: rdata_o = DATA_W'(cnt_i[LO_W-1:0]);
        REG_CNT_HI: rdata_o = DATA_W'(hi_q);
        default:    rdata_o = '0;
      endcase
    end
  end

  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_rd |=> $stable(hi_q)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0)); // R1
endmodule

// File: rtl/frac_core_timer.sv
module frac_core_timer
  import frac_tmr_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int LO_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              alt_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] presc;
  logic              presc_wr;
  logic              tick_sel;
  logic [1:0]        units;
  logic [CNT_W-1:0]  cnt;

  tmr_cfg_regs #(.DATA_W(DATA_W)) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .ctrl_o     (ctrl),
    .presc_o    (presc),
    .presc_wr_o (presc_wr)
  );

  assign tick_sel = ctrl.alt_src ? alt_tick_i : ref_tick_i;

  tmr_phase_acc #(.PRESC_W(DATA_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_sel),
    .clr_i   (presc_wr),
    .presc_i (presc),
    .units_o (units)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .units_i (units),
    .step2_i (ctrl.step2),
    .cnt_o   (cnt)
  );

  tmr_read_port #(.CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(DATA_W)) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .ctrl_i  (ctrl),
    .presc_i (presc),
    .cnt_i   (cnt),
    .rdata_o (rdata_o)
  );

  AST_ZERO_PRESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc == '0) |=> $stable(cnt)); // R6
  AST_UNSEL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl.alt_src && !alt_tick_i) || (!ctrl.alt_src && !ref_tick_i)) |=> $stable(cnt)); // R3
endmodule

// File: tb/test_frac_core_timer.sv
`timescale 1ns/1ps
module test_frac_core_timer;
  localparam int CW = 16;
  localparam int LW = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0, alt_tick_i = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [CW-1:0] m_cnt = '0;
  logic [30:0]   m_frac = '0;
  logic [31:0]   m_presc = '0;
  logic          m_alt = 1'b0, m_step = 1'b0;
  logic [15:0]   lfsr = 16'hACE1;

  always #2 clk_i = ~clk_i;

  frac_core_timer #(.CNT_W(CW), .LO_W(LW), .DATA_W(32)) i_frac_core_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .alt_tick_i(alt_tick_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model per R4/R7/R8, applied after the edge
  task automatic model_edge(input logic we, input logic [1:0] a, input logic [31:0] d,
                            input logic rt, input logic at);
    logic [32:0] s;
    if (we && a == 2'd1) m_frac = '0;
    else if (m_alt ? at : rt) begin
      s = {2'b00, m_frac} + {1'b0, m_presc};
      m_cnt = m_cnt + CW'(s[32:31]) * (m_step ? CW'(2) : CW'(1));
      m_frac = s[30:0];
    end
    if (we && a == 2'd0) begin m_alt = d[8]; m_step = d[9]; end
    if (we && a == 2'd1) m_presc = d;
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                     input logic rt, input logic at);
    @(negedge clk_i);
    wr_en_i = we; rd_en_i = 1'b0; addr_i = a; wdata_i = d;
    ref_tick_i = rt; alt_tick_i = at;
    @(posedge clk_i);
    model_edge(we, a, d, rt, at);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b1; addr_i = a; ref_tick_i = 1'b0; alt_tick_i = 1'b0;
    #1 v = rdata_o;
    @(posedge clk_i);
  endtask

  task automatic check_count(input string req);
    logic [31:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    check(req, lo, {24'h0, m_cnt[7:0]});
    check(req, hi, {24'h0, m_cnt[15:8]});
  endtask

  function automatic logic [31:0] presc_pick(input int i);
    case (i)
      0: return 32'h8000_0000;
      1: return 32'h4000_0000;
      2: return 32'h5555_5555;
      3: return 32'hC000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h0000_0001;
      default: return 32'h2AAA_AAAB;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base, exp_hi;
    repeat (3) @(posedge clk_i);
    #1 check("R1 idle rdata", rdata_o, 32'h0);
    rst_ni = 1'b1;
    // R1/R2 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reset reg", v, 32'h0);
    end
    @(negedge clk_i); rd_en_i = 1'b0; #1 check("R1 idle rdata", rdata_o, 32'h0);
    // R6 zero prescaler
    for (int k = 0; k < 20; k++) cyc(1'b0, 2'd0, 0, 1'b1, 1'b1);
    check_count("R6");
    // R2 register readback
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    rd(2'd0, v); check("R2 ctrl", v, 32'h0000_0300);
    cyc(1'b1, 2'd1, 32'h1234_5678, 1'b0, 1'b0);
    rd(2'd1, v); check("R2 presc", v, 32'h1234_5678);
    cyc(1'b1, 2'd0, 32'h0, 1'b0, 1'b0);
    // R5 exact ratio
    cyc(1'b1, 2'd1, 32'h8000_0000, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) cyc(1'b0, 2'd0, 0, 1'b1, 1'b0);
    rd(2'd2, v); check("R5 ten ticks", v, 32'd10);
    // R11 read in tick cycle vs next cycle
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b1; addr_i = 2'd2; ref_tick_i = 1'b1; alt_tick_i = 1'b0;
    #1 check("R11 same cycle", rdata_o, 32'd10);
    @(posedge clk_i); model_edge(1'b0, 2'd2, 0, 1'b1, 1'b0);
    @(negedge clk_i); ref_tick_i = 1'b0;
    #1 check("R11 next cycle", rdata_o, 32'd11);
    // R3 unselected strobe
    cyc(1'b0, 2'd0, 0, 1'b0, 1'b1);
    cyc(1'b0, 2'd0, 0, 1'b0, 1'b1);
    check_count("R3 ref selected");
    cyc(1'b1, 2'd0, 32'h100, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 0, 1'b1, 1'b0);
    cyc(1'b0, 2'd0, 0, 1'b1, 1'b0);
    rd(2'd2, v); check("R3 alt selected", v, 32'd11);
    cyc(1'b0, 2'd0, 0, 1'b0, 1'b1);
    rd(2'd2, v); check("R3 alt tick", v, 32'd12);
    cyc(1'b1, 2'd0, 32'h0, 1'b0, 1'b0);
    // R8 prescaler write clears fraction and drops tick
    cyc(1'b1, 2'd1, 32'h4000_0000, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 0, 1'b1, 1'b0);
    cyc(1'b1, 2'd1, 32'h4000_0000, 1'b1, 1'b0);
    cyc(1'b0, 2'd0, 0, 1'b1, 1'b0);
    rd(2'd2, v); check("R8 fraction cleared", v, 32'd12);
    cyc(1'b0, 2'd0, 0, 1'b1, 1'b0);
    rd(2'd2, v); check("R8 half rate", v, 32'd13);
    // R10 writes to count ignored
    cyc(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check_count("R10");
    // R9 coherent split read across a high-part change
    cyc(1'b1, 2'd1, 32'h8000_0000, 1'b0, 1'b0);
    rd(2'd2, v);
    exp_hi = {24'h0, m_cnt[15:8]};
    for (int k = 0; k < 300; k++) cyc(1'b0, 2'd0, 0, 1'b1, 1'b0);
    rd(2'd3, v); check("R9 captured high", v, exp_hi);
    check_count("R9 recapture");
    // R4/R7 sweep: prescalers x step x source, pseudo-random ticks
    for (int p = 0; p < 7; p++)
      for (int st = 0; st < 2; st++)
        for (int sr = 0; sr < 2; sr++) begin
          cyc(1'b1, 2'd0, {22'h0, st[0], sr[0], 8'h0}, 1'b0, 1'b0);
          cyc(1'b1, 2'd1, presc_pick(p), 1'b0, 1'b0);
          for (int k = 0; k < 37; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(1'b0, 2'd0, 0, lfsr[0], lfsr[3]);
          end
          check_count(st ? "R7 R4 sweep" : "R4 sweep");
        end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule